// File: doc/BRIEF.md
# Handshaked Word Crossing Between Clock Domains

This block moves a multi-bit word from a source clock domain into an unrelated destination clock domain so that the destination register only ever holds a complete word, never a mix of bits from two words. The source side keeps a captured copy of the word in a holding register. It announces each new copy by flipping a request toggle. The destination side turns the synchronized toggle into a one-cycle pulse and uses it to load its output register. It then flips an acknowledge toggle, which travels back to the source in the same way and lets the holding register take the next word.

The word itself crosses through a chain of synchronizer flops in the destination domain. The request chain is one register longer than the data chain, so the request pulse always comes after the data it qualifies has settled. The number of synchronizer stages is a parameter and applies to the request, acknowledge and data chains.

A small control state machine runs in the source domain. In state `SRC_BOOT`, entered on source reset, it issues a start-of-day request on its own and moves unconditionally to `SRC_WAIT`. In `SRC_WAIT` it stays put. It issues a request either when an acknowledge pulse returns, which also reloads the holding register, or when an optional timer expires, which resends the held word. A timeout of 0 removes the timer. With a width of 1 the block is only a plain flop chain of the configured length.

Top module: `xdom_word_sync`

## Requirements
- R1: Each domain has a synchronous active-high reset. While `dst_rst` is high, and on the cycle after it is sampled high, `dst_data` is all zeros.
- R2: `dst_data` only ever holds zero or a complete word that was present on `src_data` at some earlier source clock edge. No torn word appears.
- R3: If `src_data` is held constant, `dst_data` equals it within two request/acknowledge round trips.
- R4: `dst_data` changes only on the destination edge that closes a cycle in which the request pulse is high.
- R5: The source holding register changes only on the edge after a cycle in which the acknowledge pulse, returned into the source domain, is high. Start-of-day and timeout requests resend the held word unchanged.
- R6: The request chain has one more register than the data chain. In any cycle where the request pulse is high, the data chain output is unchanged from the previous cycle.
- R7: With TIMEOUT > 0, two source requests are never more than TIMEOUT source cycles apart. As a result the transfer recovers after a destination-only reset, whatever the parity of the request toggle. With TIMEOUT = 0 no timer exists and requests come only from start-of-day and acknowledges.
- R8: With WIDTH = 1 the block is a plain synchronizer of STAGES flops. A change on the input shows on the output after exactly STAGES destination rising edges, and not after STAGES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain synchronous reset, active high |
| src_data | input | WIDTH | Word to be carried across |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination domain synchronous reset, active high |
| dst_data | output | WIDTH | Coherent copy of the word in the destination domain |

## Verification
On every cycle the assertions check the following:
- the cleared output after a destination reset;
- that the output holds except after a request pulse;
- that the holding register loads only on a returned acknowledge;
- that the data chain is settled whenever a request pulse arrives;
- that the gap between source requests stays within the timeout.

Some behaviour only the bench scenarios can show. These are the absence of torn words across sweeps at two clock ratios in both orderings, convergence to a held value, recovery after destination-only resets of different lengths, and the exact latency of the single-bit variant.

// File: rtl/xws_pkg.sv
package xws_pkg;

    // Source-side control states
    typedef enum logic {
        SRC_BOOT = 1'b0,   // start-of-day: send one request unprompted
        SRC_WAIT = 1'b1    // waiting for acknowledge or timer expiry
    } src_state_e;

endpackage

// File: rtl/xws_sync_chain.sv
module xws_sync_chain #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/xws_pulse_cross.sv
module xws_pulse_cross #(
    parameter int SYNC_STAGES = 2
) (
    input  logic tx_clk,
    input  logic tx_rst,
    input  logic tx_fire,
    input  logic rx_clk,
    input  logic rx_rst,
    output logic rx_pulse
);

    logic tgl_q;
    logic sync_q;
    logic hold_q;

    // Sending side: every event flips the level
    always_ff @(posedge tx_clk) begin
        if (tx_rst) begin
            tgl_q <= 1'b0;
        end else if (tx_fire) begin
            tgl_q <= ~tgl_q;
        end
    end

    xws_sync_chain #(
        .WIDTH  (1),
        .STAGES (SYNC_STAGES)
    ) u_chain (
        .clk (rx_clk),
        .rst (rx_rst),
        .d   (tgl_q),
        .q   (sync_q)
    );

    // Receiving side: edge detect on the synchronized level
    always_ff @(posedge rx_clk) begin
        if (rx_rst) begin
            hold_q <= 1'b0;
        end else begin
            hold_q <= sync_q;
        end
    end

    assign rx_pulse = sync_q ^ hold_q;

endmodule

// File: rtl/xws_src_ctrl.sv
module xws_src_ctrl
    import xws_pkg::*;
#(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic ack_pulse,
    output logic launch,
    output logic load
);

    src_state_e state_q;
    src_state_e state_d;
    logic       expire;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SRC_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        unique case (state_q)
            SRC_BOOT: state_d = SRC_WAIT;
            SRC_WAIT: state_d = SRC_WAIT;
            default:  state_d = SRC_BOOT;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            SRC_BOOT: begin
                launch = 1'b1;
                load   = ack_pulse;
            end
            SRC_WAIT: begin
                launch = ack_pulse | expire;
                load   = ack_pulse;
            end
            default: begin
                launch = 1'b0;
                load   = 1'b0;
            end
        endcase
    end

    // Optional retry timer
    generate
        if (TIMEOUT > 0) begin : g_timer
            localparam int CW = $clog2(TIMEOUT + 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst || launch) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign expire = (cnt_q == CW'(TIMEOUT - 1));
        end else begin : g_no_timer
            assign expire = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/xdom_word_sync.sv
module xdom_word_sync #(
    parameter int WIDTH   = 8,
    parameter int STAGES  = 2,
    parameter int TIMEOUT = 64
) (
    input  logic             src_clk,
    input  logic             src_rst,
    input  logic [WIDTH-1:0] src_data,
    input  logic             dst_clk,
    input  logic             dst_rst,
    output logic [WIDTH-1:0] dst_data
);

    localparam int REQ_STAGES = STAGES + 1;  // one longer than the data chain

    logic             src_launch;
    logic             ack_pulse;
    logic             req_pulse;
    logic [WIDTH-1:0] src_buf;
    logic [WIDTH-1:0] data_sync;

    generate
        if (WIDTH == 1) begin : g_bit
            xws_sync_chain #(
                .WIDTH  (1),
                .STAGES (STAGES)
            ) u_bit (
                .clk (dst_clk),
                .rst (dst_rst),
                .d   (src_data),
                .q   (dst_data)
            );
            assign src_launch = 1'b0;
            assign ack_pulse  = 1'b0;
            assign req_pulse  = 1'b0;
            assign src_buf    = '0;
            assign data_sync  = '0;
        end else begin : g_word
            logic src_load;

            xws_src_ctrl #(
                .TIMEOUT (TIMEOUT)
            ) u_ctrl (
                .clk       (src_clk),
                .rst       (src_rst),
                .ack_pulse (ack_pulse),
                .launch    (src_launch),
                .load      (src_load)
            );

            always_ff @(posedge src_clk) begin
                if (src_rst) begin
                    src_buf <= '0;
                end else if (src_load) begin
                    src_buf <= src_data;
                end
            end

            xws_pulse_cross #(
                .SYNC_STAGES (REQ_STAGES)
            ) u_req (
                .tx_clk   (src_clk),
                .tx_rst   (src_rst),
                .tx_fire  (src_launch),
                .rx_clk   (dst_clk),
                .rx_rst   (dst_rst),
                .rx_pulse (req_pulse)
            );

            xws_pulse_cross #(
                .SYNC_STAGES (STAGES)
            ) u_ack (
                .tx_clk   (dst_clk),
                .tx_rst   (dst_rst),
                .tx_fire  (req_pulse),
                .rx_clk   (src_clk),
                .rx_rst   (src_rst),
                .rx_pulse (ack_pulse)
            );

            xws_sync_chain #(
                .WIDTH  (WIDTH),
                .STAGES (STAGES)
            ) u_data (
                .clk (dst_clk),
                .rst (dst_rst),
                .d   (src_buf),
                .q   (data_sync)
            );

            always_ff @(posedge dst_clk) begin
                if (dst_rst) begin
                    dst_data <= '0;
                end else if (req_pulse) begin
                    dst_data <= data_sync;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/xws_checker.sv
module xws_checker #(
    parameter int WIDTH   = 8,
    parameter int TIMEOUT = 64
) (
    input logic             src_clk,
    input logic             src_rst,
    input logic             dst_clk,
    input logic             dst_rst,
    input logic             src_launch,
    input logic             ack_pulse,
    input logic             req_pulse,
    input logic [WIDTH-1:0] src_buf,
    input logic [WIDTH-1:0] data_sync,
    input logic [WIDTH-1:0] dst_data
);

    generate
        if (WIDTH > 1) begin : g_word_chk
            AST_OUT_CLEARED: assert property (@(posedge dst_clk)
                dst_rst |=> (dst_data == '0));                                          // R1

            AST_OUT_HOLD: assert property (@(posedge dst_clk) disable iff (dst_rst)
                !req_pulse |=> $stable(dst_data));                                      // R4

            AST_BUF_HOLD: assert property (@(posedge src_clk) disable iff (src_rst)
                !ack_pulse |=> $stable(src_buf));                                       // R5

            AST_DATA_SETTLED: assert property (@(posedge dst_clk) disable iff (dst_rst)
                req_pulse |-> $stable(data_sync));                                      // R6

            if (TIMEOUT > 0) begin : g_retry_chk
                localparam int GW = $clog2(TIMEOUT + 2) + 1;
                logic [GW-1:0] gap_q;

                always_ff @(posedge src_clk) begin
                    if (src_rst || src_launch) begin
                        gap_q <= '0;
                    end else if (gap_q != '1) begin
                        gap_q <= gap_q + 1'b1;
                    end
                end

                AST_RETRY_GAP: assert property (@(posedge src_clk) disable iff (src_rst)
                    gap_q < GW'(TIMEOUT));                                              // R7
            end
        end
    endgenerate

endmodule

bind xdom_word_sync xws_checker #(
    .WIDTH   (WIDTH),
    .TIMEOUT (TIMEOUT)
) u_chk (
    .src_clk    (src_clk),
    .src_rst    (src_rst),
    .dst_clk    (dst_clk),
    .dst_rst    (dst_rst),
    .src_launch (src_launch),
    .ack_pulse  (ack_pulse),
    .req_pulse  (req_pulse),
    .src_buf    (src_buf),
    .data_sync  (data_sync),
    .dst_data   (dst_data)
);

// File: tb/sim_xdom_word_sync.sv
module sim_xdom_word_sync;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int W = 8;
    localparam int S = 2;
    localparam int T = 64;

    logic         src_clk  = 1'b0;
    logic         dst_clk  = 1'b0;
    logic         src_rst  = 1'b1;
    logic         dst_rst  = 1'b1;
    logic [W-1:0] src_data = '0;
    logic [W-1:0] dst_data;
    logic         bit_in   = 1'b0;
    logic         bit_out;

    real dst_half = 3.5;

    int errors = 0;
    int checks = 0;

    logic [W-1:0] hist [256];
    int           hist_n = 1;
    logic [W-1:0] last_seen = '0;
    logic         mon_en = 1'b0;

    // 50 MHz source clock; destination edges always fall off the source grid
    always #10 src_clk = ~src_clk;
    initial begin
        #1.3;
        forever #(dst_half) dst_clk = ~dst_clk;
    end

    xdom_word_sync #(.WIDTH(W), .STAGES(S), .TIMEOUT(T)) u0 (
        .src_clk  (src_clk),
        .src_rst  (src_rst),
        .src_data (src_data),
        .dst_clk  (dst_clk),
        .dst_rst  (dst_rst),
        .dst_data (dst_data)
    );

    xdom_word_sync #(.WIDTH(1), .STAGES(S), .TIMEOUT(T)) u1 (
        .src_clk  (src_clk),
        .src_rst  (src_rst),
        .src_data (bit_in),
        .dst_clk  (dst_clk),
        .dst_rst  (dst_rst),
        .dst_data (bit_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit in_hist(input logic [W-1:0] v);
        for (int i = 0; i < hist_n; i++) begin
            if (hist[i] == v) return 1'b1;
        end
        return 1'b0;
    endfunction

    // Words carry a self-check: upper nibble is the complement of the lower
    task automatic drive(input int k);
        @(negedge src_clk);
        src_data = {k[3:0], ~k[3:0]};
        if (hist_n < 256) begin
            hist[hist_n] = src_data;
            hist_n++;
        end
    endtask

    task automatic settle();
        repeat (12) @(posedge dst_clk);
        repeat (12) @(posedge src_clk);
        repeat (12) @(posedge dst_clk);
        @(negedge dst_clk);
    endtask

    // R2, R5, R6: every new output word is coherent and was driven before
    always @(negedge dst_clk) begin
        if (mon_en && dst_data !== last_seen) begin
            chk(in_hist(dst_data) && (dst_data == '0 || dst_data[7:4] == ~dst_data[3:0]),
                "R2,R5,R6 torn or unknown word", dst_data, last_seen);
            last_seen = dst_data;
        end
    end

    task automatic run_phase(input real half, input int base, input bit do_bit);
        bit stable_ok;
        dst_half = half;
        @(negedge src_clk) src_rst = 1'b1;
        @(negedge dst_clk) dst_rst = 1'b1;
        repeat (4) @(posedge src_clk);
        repeat (4) @(posedge dst_clk);
        @(negedge dst_clk);
        chk(dst_data == '0, "R1 output during reset", dst_data, '0);
        @(negedge src_clk) src_rst = 1'b0;
        @(negedge dst_clk) dst_rst = 1'b0;
        mon_en = 1'b1;

        // sweep with varying hold times
        for (int k = 0; k < 24; k++) begin
            drive(base + k);
            repeat (k % 5) @(posedge src_clk);
            if (k % 6 == 5) begin
                settle();
                chk(dst_data == src_data, "R3 held value reached", dst_data, src_data);
            end
        end

        // R4: with the input held, the output does not move
        settle();
        stable_ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge dst_clk);
            if (dst_data !== src_data) stable_ok = 1'b0;
        end
        chk(stable_ok, "R4 output held steady", dst_data, src_data);

        // R8: single-bit variant latency
        if (do_bit) begin
            for (int t = 0; t < 6; t++) begin
                @(negedge src_clk) bit_in = ~bit_in;
                repeat (S - 1) @(posedge dst_clk);
                @(negedge dst_clk);
                chk(bit_out == ~bit_in, "R8 old value before last stage", W'(bit_out), W'(~bit_in));
                @(posedge dst_clk);
                @(negedge dst_clk);
                chk(bit_out == bit_in, "R8 new value after STAGES edges", W'(bit_out), W'(bit_in));
                repeat (4) @(posedge dst_clk);
            end
        end

        // R7: destination-only resets of differing length
        for (int j = 0; j < 4; j++) begin
            drive(base + 40 + j);
            @(negedge dst_clk) dst_rst = 1'b1;
            @(negedge dst_clk);
            chk(dst_data == '0, "R1 output during destination reset", dst_data, '0);
            repeat (150 + 37 * j) @(posedge src_clk);
            drive(base + 60 + j);
            @(negedge dst_clk) dst_rst = 1'b0;
            repeat (2 * T) @(posedge src_clk);
            settle();
            settle();
            chk(dst_data == src_data, "R7 recovery after destination reset", dst_data, src_data);
        end
    endtask

    initial begin
        hist[0] = '0;
        run_phase(3.5, 1, 1'b1);    // destination faster than source
        run_phase(26.5, 5, 1'b0);   // destination slower than source
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #3000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule